// File: doc/BRIEF.md
# Multifunction Prescaler Timer

This block is a free-running timer built on one binary divider chain that is clocked by the internal bus clock. The same chain does four jobs. It gives software a readable 8-bit view of the count. It raises an overflow event every 1024 clocks. It raises a periodic real-time event at one of four selectable rates. Before any of these run, it times the oscillator stabilization delay that follows power-up.

After reset is released, the chain first counts out the stabilization delay. The delay is long by default and short when the short-delay option input is high. The chain then clears, `stab_done_o` rises, and normal timing begins. The same sequence applies when stop mode is left through reset. Software reaches the block through one 8-bit control/status register. The register holds two sticky event flags, two interrupt enables, two write-one-to-clear strobes that always read back as zero, and a two-bit rate select. The interrupt request is the OR of the two enabled flags, so an enabled event can also end wait mode. A one-cycle tick marks every real-time period, whatever the enables are, and serves as the time base for a watchdog.

Top module: `timer_multi`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ctrl_rdata_o`, `cnt_o`, `irq_o`, `rti_tick_o` and `stab_done_o` are all zero.
- R2: `stab_done_o` rises exactly STAB_LONG (4064) clock edges after reset release when `short_delay_i` is 0, and STAB_SHORT (128) edges after it when `short_delay_i` is 1. It then stays high. Neither flag can set before it rises.
- R3: `cnt_o` shows chain bits [9:2]. After `stab_done_o` rises it equals (t/4) mod 256, where t is the number of edges since the rise. During the delay it shows the same bits of the delay count.
- R4: The overflow flag (register bit 7) sets at every edge where t is a nonzero multiple of 1024.
- R5: The real-time flag (bit 6) sets at every edge where t is a nonzero multiple of 2^(RTI_BASE+rate). Rate is register bits [1:0], and RTI_BASE defaults to 14, which gives periods of 2^14 to 2^17 clocks.
- R6: `rti_tick_o` is high for exactly the one cycle that follows each edge that sets the real-time flag, whatever the enables are.
- R7: A write with bit 4 set clears the overflow flag, and a write with bit 5 set clears the real-time flag. A write with the bit at 0 leaves that flag unchanged. Bits 5 and 4 always read 0.
- R8: If a flag's event and its clear write fall on the same edge, the flag ends up set.
- R9: Bit 2 (overflow enable), bit 3 (real-time enable) and bits [1:0] (rate) are written by every write and read back. `irq_o` = (bit7 AND bit2) OR (bit6 AND bit3).
- R10: Asserting reset in the middle of a run restarts the whole sequence: the chain clears, the flags and register clear, and a fresh stabilization delay is timed, using the value of `short_delay_i` at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up or stop exit) |
| short_delay_i | input | 1 | Option: 1 selects the short stabilization delay |
| wr_en_i | input | 1 | Write strobe for the control/status register |
| wr_data_i | input | 8 | Write data |
| ctrl_rdata_o | output | 8 | Control/status register read value |
| cnt_o | output | 8 | Readable counter view (chain bits 9:2) |
| irq_o | output | 1 | Timer interrupt request |
| rti_tick_o | output | 1 | One-cycle real-time period tick for a watchdog |
| stab_done_o | output | 1 | Stabilization delay elapsed; timer running |

## Verification
The bound checker watches, on every cycle, these local rules: the set-wins-over-clear rule, clearing when no event is present, a tick always coming with a set flag, a tick lasting one cycle, the interrupt needing a flag, no flag before stabilization, the done signal staying high, and the counter view stepping by at most one. The exact delay lengths for both option values, the 1024-clock overflow period, each rate's period after rate changes, and a restart through a mid-run reset depend on counting over long windows. Only the bench's reference model, compared on every cycle under random register writes and directed cases, can show these.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W        = 8;
  localparam int RATE_W       = 2;
  localparam int RATE_LSB     = 0;
  localparam int OVF_EN_BIT   = 2;
  localparam int RTI_EN_BIT   = 3;
  localparam int OVF_CLR_BIT  = 4;
  localparam int RTI_CLR_BIT  = 5;
  localparam int RTI_FLAG_BIT = 6;
  localparam int OVF_FLAG_BIT = 7;

  typedef struct packed {
    logic              ovf_flag;
    logic              rti_flag;
    logic              rti_en;
    logic              ovf_en;
    logic [RATE_W-1:0] rate;
  } tmr_state_t;
endpackage

// File: rtl/tmr_chain.sv
module tmr_chain #(
  parameter int CHAIN_W    = 17,
  parameter int STAB_LONG  = 4064,
  parameter int STAB_SHORT = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               short_i,
  output logic [CHAIN_W-1:0] div_o,
  output logic               run_o
);
  localparam logic [CHAIN_W-1:0] LAST_LONG  = CHAIN_W'(STAB_LONG - 1);
  localparam logic [CHAIN_W-1:0] LAST_SHORT = CHAIN_W'(STAB_SHORT - 1);

  logic [CHAIN_W-1:0] stab_last;
  assign stab_last = short_i ? LAST_SHORT : LAST_LONG;

  // one chain: first times the start-up delay, then runs free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o <= '0;
      run_o <= 1'b0;
    end else if (!run_o && div_o == stab_last) begin
      div_o <= '0;
      run_o <= 1'b1;
    end else begin
      div_o <= div_o + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_events.sv
module tmr_events #(
  parameter int CHAIN_W  = 17,
  parameter int PRE_W    = 2,
  parameter int VIEW_W   = 8,
  parameter int RTI_BASE = 14,
  parameter int RATE_W   = 2
) (
  input  logic [CHAIN_W-1:0] div_i,
  input  logic               run_i,
  input  logic [RATE_W-1:0]  rate_i,
  output logic               ovf_evt_o,
  output logic               rti_evt_o,
  output logic [VIEW_W-1:0]  view_o
);
  localparam int OVF_W  = PRE_W + VIEW_W;
  localparam int N_TAPS = 1 << RATE_W;

  logic [N_TAPS-1:0] tap_hit;

  // a tap fires on the cycle its low bits are all ones (carry next edge)
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign tap_hit[g] = &div_i[RTI_BASE+g-1:0];
  end

  assign ovf_evt_o = run_i & (&div_i[OVF_W-1:0]);
  assign rti_evt_o = run_i & tap_hit[rate_i];
  assign view_o    = div_i[OVF_W-1:PRE_W];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ovf_evt_i,
  input  logic             rti_evt_i,
  output logic [RATE_W-1:0] rate_o,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             tick_o
);
  tmr_state_t st_q, st_d;
  logic       tick_q;

  always_comb begin
    st_d = st_q;
    if (ovf_evt_i)                              st_d.ovf_flag = 1'b1;
    else if (wr_en_i && wr_data_i[OVF_CLR_BIT]) st_d.ovf_flag = 1'b0;
    if (rti_evt_i)                              st_d.rti_flag = 1'b1;
    else if (wr_en_i && wr_data_i[RTI_CLR_BIT]) st_d.rti_flag = 1'b0;
    if (wr_en_i) begin
      st_d.ovf_en = wr_data_i[OVF_EN_BIT];
      st_d.rti_en = wr_data_i[RTI_EN_BIT];
      st_d.rate   = wr_data_i[RATE_LSB +: RATE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tick_q <= rti_evt_i;
    end
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[OVF_FLAG_BIT]          = st_q.ovf_flag;
    rdata_o[RTI_FLAG_BIT]          = st_q.rti_flag;
    rdata_o[OVF_EN_BIT]            = st_q.ovf_en;
    rdata_o[RTI_EN_BIT]            = st_q.rti_en;
    rdata_o[RATE_LSB +: RATE_W]    = st_q.rate;
  end

  assign rate_o = st_q.rate;
  assign irq_o  = (st_q.ovf_flag & st_q.ovf_en) | (st_q.rti_flag & st_q.rti_en);
  assign tick_o = tick_q;
endmodule

// File: rtl/timer_multi.sv
module timer_multi #(
  parameter int PRE_W      = 2,
  parameter int VIEW_W     = 8,
  parameter int RTI_BASE   = 14,
  parameter int STAB_LONG  = 4064,
  parameter int STAB_SHORT = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              short_delay_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        ctrl_rdata_o,
  output logic [VIEW_W-1:0] cnt_o,
  output logic              irq_o,
  output logic              rti_tick_o,
  output logic              stab_done_o
);
  import tmr_pkg::*;

  localparam int CHAIN_W = RTI_BASE + (1 << RATE_W) - 1;

  logic [CHAIN_W-1:0] div;
  logic               run;
  logic [RATE_W-1:0]  rate;
  logic               ovf_evt, rti_evt;

  tmr_chain #(
    .CHAIN_W(CHAIN_W), .STAB_LONG(STAB_LONG), .STAB_SHORT(STAB_SHORT)
  ) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .short_i(short_delay_i),
    .div_o(div), .run_o(run)
  );

  tmr_events #(
    .CHAIN_W(CHAIN_W), .PRE_W(PRE_W), .VIEW_W(VIEW_W),
    .RTI_BASE(RTI_BASE), .RATE_W(RATE_W)
  ) u_events (
    .div_i(div), .run_i(run), .rate_i(rate),
    .ovf_evt_o(ovf_evt), .rti_evt_o(rti_evt), .view_o(cnt_o)
  );

  tmr_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ovf_evt_i(ovf_evt), .rti_evt_i(rti_evt),
    .rate_o(rate), .rdata_o(ctrl_rdata_o),
    .irq_o(irq_o), .tick_o(rti_tick_o)
  );

  assign stab_done_o = run;
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks #(
  parameter int VIEW_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [7:0]        wr_data_i,
  input logic [7:0]        ctrl_rdata_o,
  input logic [VIEW_W-1:0] cnt_o,
  input logic              irq_o,
  input logic              rti_tick_o,
  input logic              stab_done_o,
  input logic              ovf_evt,
  input logic              rti_evt
);
  a_r8_ovf_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> ctrl_rdata_o[7]);

  a_r8_rti_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_evt |=> ctrl_rdata_o[6]);

  a_r7_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[4] && !ovf_evt) |=> !ctrl_rdata_o[7]);

  a_r7_rti_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[5] && !rti_evt) |=> !ctrl_rdata_o[6]);

  a_r6_tick_has_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_tick_o |-> ctrl_rdata_o[6]);

  a_r6_tick_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_tick_o |=> !rti_tick_o);

  a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_rdata_o[7] || ctrl_rdata_o[6]));

  a_r2_no_flag_in_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stab_done_o |-> (ctrl_rdata_o[7:6] == 2'b00));

  a_r2_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stab_done_o |=> stab_done_o);

  a_r3_view_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stab_done_o && $past(stab_done_o)) |->
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

bind timer_multi tmr_checks #(.VIEW_W(VIEW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .ctrl_rdata_o(ctrl_rdata_o), .cnt_o(cnt_o), .irq_o(irq_o),
  .rti_tick_o(rti_tick_o), .stab_done_o(stab_done_o),
  .ovf_evt(ovf_evt), .rti_evt(rti_evt)
);

// File: tb/sim_timer_multi.sv
module sim_timer_multi;
  localparam int RB    = 11;
  localparam int LONGD = 4064;
  localparam int SHORTD = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       short_d = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rdata, cnt;
  logic       irq, tick, done;

  timer_multi #(.RTI_BASE(RB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .short_delay_i(short_d),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ctrl_rdata_o(rdata),
    .cnt_o(cnt), .irq_o(irq), .rti_tick_o(tick), .stab_done_o(done)
  );

  always #2 clk = ~clk;

  int  n_vec = 0, n_bad = 0;
  bit  cmp_on = 0, finished = 0;

  // reference model, advanced at each rising edge
  int  m_stab, m_t;
  bit  m_done, m_ovf, m_rti, m_oen, m_ren, m_tick;
  bit [1:0] m_rate;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stab = 0; m_t = 0; m_done = 0; m_ovf = 0; m_rti = 0;
      m_oen = 0; m_ren = 0; m_rate = 0; m_tick = 0;
    end else begin
      bit oe, re;
      oe = 0; re = 0;
      if (!m_done) begin
        m_stab++;
        if (m_stab == (short_d ? SHORTD : LONGD)) begin m_done = 1; m_t = 0; end
      end else begin
        m_t++;
        oe = (m_t % 1024) == 0;
        re = (m_t % (1 << (RB + m_rate))) == 0;
      end
      m_tick = re;
      if (oe) m_ovf = 1; else if (wr_en && wr_data[4]) m_ovf = 0;
      if (re) m_rti = 1; else if (wr_en && wr_data[5]) m_rti = 0;
      if (wr_en) begin m_oen = wr_data[2]; m_ren = wr_data[3]; m_rate = wr_data[1:0]; end
    end
  end

  function automatic logic [7:0] exp_rdata();
    return {m_ovf, m_rti, 2'b00, m_ren, m_oen, m_rate};
  endfunction
  function automatic logic [7:0] exp_cnt();
    return m_done ? 8'((m_t >> 2) & 255) : 8'((m_stab >> 2) & 255);
  endfunction
  function automatic logic exp_irq();
    return (m_ovf & m_oen) | (m_rti & m_ren);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) if (cmp_on && rst_n) begin
    chk("R2 stab_done", 32'(done), 32'(m_done));
    chk("R3 cnt_o", 32'(cnt), 32'(exp_cnt()));
    chk("R4/R5/R7/R9 rdata", 32'(rdata), 32'(exp_rdata()));
    chk("R6 rti_tick", 32'(tick), 32'(m_tick));
    chk("R9 irq_o", 32'(irq), 32'(exp_irq()));
  end

  task automatic write_reg(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 63) == 0) begin
        logic [7:0] d;
        d = 8'($urandom());
        // keep clears rare so flags are observed
        if ($urandom_range(0, 3) != 0) d[5:4] = 2'b00;
        write_reg(d);
      end else @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 195000);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    idle(3);
    chk("R1 rdata", 32'(rdata), 0);
    chk("R1 cnt", 32'(cnt), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tick", 32'(tick), 0);
    chk("R1 done", 32'(done), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    // R2: long delay edges
    idle(LONGD - 1);
    chk("R2 not done before 4064", 32'(done), 0);
    idle(1);
    chk("R2 done at 4064", 32'(done), 1);
    chk("R3 view cleared at done", 32'(cnt), 0);
    // R4 + R9: overflow with enable
    write_reg(8'b0000_0100);
    idle(1030);
    chk("R4 ovf flag set", 32'(rdata[7]), 1);
    chk("R9 irq from ovf", 32'(irq), 1);
    // R7: clear with zero bit does nothing, then clear
    write_reg(8'b0000_0100);
    chk("R7 zero clear keeps flag", 32'(rdata[7]), 1);
    write_reg(8'b0001_0100);
    chk("R7 ovf cleared", 32'(rdata[7]), 0);
    chk("R7 clear bits read 0", 32'(rdata[5:4]), 0);
    // R8: clear on the same edge the overflow event lands
    while ((m_t % 1024) != 1023) @(negedge clk);
    write_reg(8'b0001_0000);
    chk("R8 set wins over clear", 32'(rdata[7]), 1);
    // R5 + R6: fastest rate with enable
    write_reg(8'b0011_1000);
    while (!tick) @(negedge clk);
    chk("R6 tick period boundary", 32'(m_t % (1 << RB)), 0);
    chk("R5 rti flag", 32'(rdata[6]), 1);
    chk("R9 irq from rti", 32'(irq), 1);
    random_phase(40000);
    // R10: reset mid-run with short delay
    short_d = 1'b1;
    rst_n = 1'b0;
    idle(2);
    chk("R10 rdata cleared", 32'(rdata), 0);
    chk("R10 done cleared", 32'(done), 0);
    rst_n = 1'b1;
    idle(SHORTD - 1);
    chk("R10 not done before 128", 32'(done), 0);
    idle(1);
    chk("R10 done at 128", 32'(done), 1);
    write_reg(8'b0000_1011);
    random_phase(60000);
    cmp_on = 0;
    finish_run();
  end
endmodule